// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and its read side run on separate clocks, which may be the same clock or two unrelated ones. Each side accepts a transfer only when both of its enable inputs are active. Words leave through a registered output stage, and an output-enable input drives a separate signal that tells the pad logic whether to drive or float that output. The storage depth is a power-of-two parameter between 64 and 8192 words.

Four status flags are provided. Full and almost-full are computed on the write clock. Empty and almost-empty are computed on the read clock. The two near-limit flags compare against two offset values, and software loads those offsets through the same write port that carries data. If reset is released while the second write enable is held low, the block enters a loading phase. In that phase, each strobe of the first write enable stores the data word into an offset register instead of the buffer. The first strobe loads the near-empty offset and the second loads the near-full offset, and further strobes keep alternating between the two. Raising the second write enable ends the loading phase, and normal buffering starts.

Each pointer crosses into the other clock domain as Gray code through a chain of flip-flops. A single active-low reset input clears both sides at once. Each domain releases that reset in step with its own clock.

Top module: `dcf_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge only when `wr_req_n` is 0 and `wr_arm_ld` is 1 (outside the loading phase). If either enable is inactive, the word is not stored. Words are returned in the order they were written.
- R2: A read takes place on a rising `rd_clk` edge only when `rd_req_n` and `rd_arm_n` are both 0 and the buffer is not empty. At that edge, `rd_data` takes the oldest stored word. Otherwise `rd_data` holds its value.
- R3: A write attempted while `full` is 1 is ignored. The pointer does not move, no stored word is changed, and the rejected word never appears at the output.
- R4: A read attempted while `empty` is 1 is ignored. `rd_data` holds its value, `empty` stays 1, and the read pointer does not move.
- R5: After reset, `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, and `rd_data` is 0. Both offsets are 7.
- R6: `almost_empty` is 1 when the word count seen in the read domain is less than or equal to the near-empty offset.
- R7: `almost_full` is 1 when DEPTH minus the word count seen in the write domain is less than or equal to the near-full offset.
- R8: `full` becomes 1 at the `wr_clk` edge that stores the DEPTH-th word. `empty` goes to 0 a few `rd_clk` edges after the first write, and goes back to 1 once the last word has been read.
- R9: If `wr_arm_ld` is 0 when reset is released, the loading phase begins. In that phase, each edge with `wr_req_n` 0 and `wr_arm_ld` 0 loads `wr_data`. Loads alternate between the near-empty offset (first) and the near-full offset (second), and none of them writes into the buffer. The first edge with `wr_arm_ld` 1 ends the phase.
- R10: `rd_data_oe` is 1 exactly when `oe_n` is 0.
- R11: With both clocks running and both sides transferring at the same time, every word that is accepted is read back once, in order, with no loss.
- R12: Between consecutive edges of its own clock, each pointer that crosses domains changes in at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Master reset, active low, asynchronous assertion |
| wr_clk | input | 1 | Write-side clock |
| wr_req_n | input | 1 | Write enable, active low; also the load strobe in the loading phase |
| wr_arm_ld | input | 1 | Second write enable, active high; when low at reset release it selects the loading phase |
| wr_data | input | 9 | Word to store, or offset value to load |
| full | output | 1 | Buffer holds DEPTH words (write domain) |
| almost_full | output | 1 | Free space is at or below the near-full offset |
| rd_clk | input | 1 | Read-side clock |
| rd_req_n | input | 1 | Read enable, active low |
| rd_arm_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 9 | Registered output word |
| rd_data_oe | output | 1 | Drive control for `rd_data` (1 means drive, 0 means float) |
| empty | output | 1 | No words are visible to the read side |
| almost_empty | output | 1 | Word count is at or below the near-empty offset |

## Verification
The two functions that can fall in the same clock cycle are a write and a read on their unrelated clocks. This includes a write arriving at a full buffer in the same cycle that the reader frees a slot. The streaming scenario runs the write clock faster than the read clock, so the writer keeps filling the buffer to full and then stalls until the reader catches up. The writer enqueues only when `full` was low at the edge where it drove the word. The result is judged by comparing every word read back against that accepted sequence, so a dropped, duplicated or reordered word shows up as a mismatch.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Shared constants and types for the dual-clock buffer.
  localparam int DATA_W      = 9;
  localparam int OFFSET_INIT = 7;

  // Write-side operating phase.
  typedef enum logic [1:0] {
    WM_START = 2'd0,   // first cycle after reset release: sample the load select
    WM_FIFO  = 2'd1,   // normal buffering
    WM_LOAD  = 2'd2    // offset programming
  } wr_mode_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = DATA_W,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_n,
  input  logic          arm_ld,
  input  logic [DW-1:0] din,
  input  logic [PW-1:0] rd_gray_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] wr_gray,
  output logic          full,
  output logic          almost_full,
  output logic [DW-1:0] ae_off
);
  localparam int CW = (PW > DW) ? PW : DW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  wr_mode_e      mode_q, mode_d;
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [PW-1:0] rd_bin, count, free;
  logic [DW-1:0] ae_q, ae_d, af_q, af_d;
  logic          sel_q, sel_d;
  logic          push, load;

  always_comb begin
    rd_bin[PW-1] = rd_gray_s[PW-1];
    for (int i = PW-2; i >= 0; i--) rd_bin[i] = rd_bin[i+1] ^ rd_gray_s[i];

    count       = bin_q - rd_bin;
    free        = DEPTH_P - count;
    full        = (count == DEPTH_P);
    almost_full = (CW'(free) <= CW'(af_q));

    push = (mode_q == WM_FIFO) && !req_n &&  arm_ld && !full;
    load = (mode_q == WM_LOAD) && !req_n && !arm_ld;

    mode_d = mode_q;
    case (mode_q)
      WM_START: mode_d = arm_ld ? WM_FIFO : WM_LOAD;
      WM_LOAD:  if (arm_ld) mode_d = WM_FIFO;
      default:  mode_d = mode_q;
    endcase

    bin_d  = push ? bin_q + PW'(1) : bin_q;
    gray_d = bin_d ^ (bin_d >> 1);

    ae_d  = ae_q;
    af_d  = af_q;
    sel_d = sel_q;
    if (load) begin
      if (!sel_q) ae_d = din;
      else        af_d = din;
      sel_d = !sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WM_START;
      bin_q  <= '0;
      gray_q <= '0;
      ae_q   <= DW'(OFFSET_INIT);
      af_q   <= DW'(OFFSET_INIT);
      sel_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bin_q  <= bin_d;
      gray_q <= gray_d;
      ae_q   <= ae_d;
      af_q   <= af_d;
      sel_q  <= sel_d;
    end
  end

  assign mem_we   = push;
  assign mem_addr = bin_q[AW-1:0];
  assign wr_gray  = gray_q;
  assign ae_off   = ae_q;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = DATA_W,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_n,
  input  logic          arm_n,
  input  logic [PW-1:0] wr_gray_s,
  input  logic [DW-1:0] ae_off,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] rd_gray,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam int CW = (PW > DW) ? PW : DW;

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [PW-1:0] wr_bin, count;
  logic [DW-1:0] data_q, data_d;
  logic          pop;

  always_comb begin
    wr_bin[PW-1] = wr_gray_s[PW-1];
    for (int i = PW-2; i >= 0; i--) wr_bin[i] = wr_bin[i+1] ^ wr_gray_s[i];

    count        = wr_bin - bin_q;
    empty        = (count == '0);
    almost_empty = (CW'(count) <= CW'(ae_off));

    pop    = !req_n && !arm_n && !empty;
    bin_d  = pop ? bin_q + PW'(1) : bin_q;
    gray_d = bin_d ^ (bin_d >> 1);
    data_d = pop ? mem_rdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      data_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      data_q <= data_d;
    end
  end

  assign mem_addr = bin_q[AW-1:0];
  assign rd_gray  = gray_q;
  assign rd_data  = data_q;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int DW          = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_req_n,
  input  logic          wr_arm_ld,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  input  logic          rd_clk,
  input  logic          rd_req_n,
  input  logic          rd_arm_n,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_data_oe,
  output logic          empty,
  output logic          almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_rst_n, rd_rst_n;
  logic [PW-1:0] wr_ptr_gray, rd_ptr_gray, wr_gray_rs, rd_gray_ws;
  logic          mem_we;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] ae_off, mem_rdata;
  logic [DW-1:0] mem [DEPTH];

  dcf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .arst_n(rst_n), .rst_n_o(wr_rst_n));
  dcf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .arst_n(rst_n), .rst_n_o(rd_rst_n));

  dcf_sync2 #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_to_w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_ptr_gray), .q(rd_gray_ws));
  dcf_sync2 #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_to_r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_ptr_gray), .q(wr_gray_rs));

  dcf_wr_ctl #(.DEPTH(DEPTH), .DW(DW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .req_n(wr_req_n), .arm_ld(wr_arm_ld),
    .din(wr_data), .rd_gray_s(rd_gray_ws), .mem_we(mem_we), .mem_addr(wr_addr),
    .wr_gray(wr_ptr_gray), .full(full), .almost_full(almost_full), .ae_off(ae_off));

  dcf_rd_ctl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .req_n(rd_req_n), .arm_n(rd_arm_n),
    .wr_gray_s(wr_gray_rs), .ae_off(ae_off), .mem_rdata(mem_rdata),
    .mem_addr(rd_addr), .rd_gray(rd_ptr_gray), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty));

  // Storage: written on the write clock, read through the output register.
  always_ff @(posedge wr_clk) begin
    if (mem_we) mem[wr_addr] <= wr_data;
  end

  assign mem_rdata  = mem[rd_addr];
  assign rd_data_oe = !oe_n;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int PW = 7
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n,
  input logic          rd_rst_n,
  input logic [PW-1:0] wr_ptr_gray,
  input logic [PW-1:0] rd_ptr_gray,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty
);
  assert_full_blocks_write_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full |=> $stable(wr_ptr_gray));

  assert_empty_blocks_read_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    empty |=> $stable(rd_ptr_gray));

  assert_empty_in_almost_empty_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    empty |-> almost_empty);

  assert_full_in_almost_full_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full |-> almost_full);

  assert_wr_gray_one_bit_R12: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    1'b1 |=> $onehot0(wr_ptr_gray ^ $past(wr_ptr_gray)));

  assert_rd_gray_one_bit_R12: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    1'b1 |=> $onehot0(rd_ptr_gray ^ $past(rd_ptr_gray)));
endmodule

bind dcf_fifo dcf_fifo_chk #(.PW(PW)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_ptr_gray(wr_ptr_gray), .rd_ptr_gray(rd_ptr_gray),
  .full(full), .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty));

// File: tb/dcf_fifo_tb_top.sv
module dcf_fifo_tb_top;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DEPTH     = 64;
  localparam int DW        = 9;

  logic          rst_n, wr_clk, rd_clk;
  logic          wr_req_n, wr_arm_ld, rd_req_n, rd_arm_n, oe_n;
  logic [DW-1:0] wr_data, rd_data;
  logic          full, almost_full, empty, almost_empty, rd_data_oe;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] model [$];

  dcf_fifo #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_req_n(wr_req_n), .wr_arm_ld(wr_arm_ld),
    .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .rd_clk(rd_clk), .rd_req_n(rd_req_n), .rd_arm_n(rd_arm_n), .oe_n(oe_n),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .empty(empty), .almost_empty(almost_empty));

  initial begin wr_clk = 0; forever #(WR_PERIOD/2) wr_clk = ~wr_clk; end
  initial begin rd_clk = 0; forever #(RD_PERIOD/2) rd_clk = ~rd_clk; end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic do_reset(input bit load_phase);
    rst_n = 0; wr_req_n = 1; wr_arm_ld = !load_phase;
    rd_req_n = 1; rd_arm_n = 1; oe_n = 1; wr_data = '0;
    model.delete();
    repeat (4) @(negedge wr_clk);
    rst_n = 1;
    repeat (6) @(negedge wr_clk);
    settle();
  endtask

  task automatic push(input logic [DW-1:0] d);
    bit ok;
    @(negedge wr_clk);
    ok = !full; wr_req_n = 0; wr_data = d;
    @(negedge wr_clk);
    wr_req_n = 1;
    if (ok) model.push_back(d);
  endtask

  task automatic pop_chk(input string req);
    bit ok;
    logic [DW-1:0] e;
    @(negedge rd_clk);
    ok = !empty; rd_req_n = 0; rd_arm_n = 0;
    @(negedge rd_clk);
    rd_req_n = 1; rd_arm_n = 1;
    if (ok) begin
      e = (model.size() > 0) ? model.pop_front() : '0;
      chk(req, int'(rd_data), int'(e));
    end
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) pop_chk(req);
    settle();
    chk({req, " empty after drain"}, int'(empty), 1);
  endtask

  // R5: reset state
  task automatic t_reset();
    do_reset(0);
    chk("R5 empty",        int'(empty), 1);
    chk("R5 almost_empty", int'(almost_empty), 1);
    chk("R5 full",         int'(full), 0);
    chk("R5 almost_full",  int'(almost_full), 0);
    chk("R5 rd_data",      int'(rd_data), 0);
  endtask

  // R10: output drive control
  task automatic t_oe();
    oe_n = 0; #1;
    chk("R10 oe active", int'(rd_data_oe), 1);
    oe_n = 1; #1;
    chk("R10 oe idle", int'(rd_data_oe), 0);
  endtask

  // R1, R2, R4, R8: basic ordering, gating and empty behaviour
  task automatic t_basic();
    @(negedge wr_clk); wr_req_n = 0; wr_arm_ld = 0; wr_data = 9'h155;
    repeat (2) @(negedge wr_clk);
    wr_req_n = 1; wr_arm_ld = 1;
    settle();
    chk("R1 half-enabled write ignored", int'(empty), 1);
    for (int i = 0; i < 10; i++) push(DW'(i * 37 + 3));
    settle();
    chk("R8 empty clears after writes", int'(empty), 0);
    @(negedge rd_clk); rd_req_n = 0; rd_arm_n = 1;
    repeat (2) @(negedge rd_clk);
    rd_req_n = 1;
    chk("R2 half-enabled read holds output", int'(rd_data), 0);
    drain("R2 R1 order");
    @(negedge rd_clk); rd_req_n = 0; rd_arm_n = 0;
    repeat (2) @(negedge rd_clk);
    rd_req_n = 1; rd_arm_n = 1;
    chk("R4 read while empty holds data", int'(rd_data), (9 * 37 + 3) & 9'h1ff);
    chk("R4 empty stays set", int'(empty), 1);
  endtask

  // R5, R6: default near-empty offset of 7
  task automatic t_ae_default();
    for (int i = 0; i < 7; i++) push(DW'(100 + i));
    settle();
    chk("R6 R5 count 7 almost_empty", int'(almost_empty), 1);
    push(9'd107);
    settle();
    chk("R6 R5 count 8 almost_empty", int'(almost_empty), 0);
    drain("R6 data");
  endtask

  // R7, R8, R3: default near-full offset, full, overflow rejection
  task automatic t_full();
    for (int i = 0; i < DEPTH - 8; i++) push(DW'(i * 11 + 1));
    chk("R7 R5 free 8 almost_full", int'(almost_full), 0);
    push(9'h0f0);
    chk("R7 R5 free 7 almost_full", int'(almost_full), 1);
    for (int i = DEPTH - 7; i < DEPTH - 1; i++) push(DW'(i * 5));
    chk("R8 one free slot full", int'(full), 0);
    push(9'h0aa);
    chk("R8 full at DEPTH words", int'(full), 1);
    @(negedge wr_clk); wr_req_n = 0; wr_data = 9'h1aa;
    @(negedge wr_clk); wr_req_n = 1;
    chk("R3 full holds after rejected write", int'(full), 1);
    settle();
    drain("R3 contents intact");
  endtask

  // R9: offset loading phase, then thresholds 3 and 5
  task automatic t_load();
    do_reset(1);
    @(negedge wr_clk); wr_req_n = 0; wr_data = 9'd3;
    @(negedge wr_clk); wr_req_n = 1;
    @(negedge wr_clk); wr_req_n = 0; wr_data = 9'd5;
    @(negedge wr_clk); wr_req_n = 1;
    @(negedge wr_clk); wr_arm_ld = 1;
    settle();
    chk("R9 loads do not fill buffer", int'(empty), 1);
    for (int i = 0; i < 3; i++) push(DW'(200 + i));
    settle();
    chk("R9 R6 count 3 almost_empty", int'(almost_empty), 1);
    push(9'd203);
    settle();
    chk("R9 R6 count 4 almost_empty", int'(almost_empty), 0);
    for (int i = 4; i < DEPTH - 6; i++) push(DW'(i * 3));
    chk("R9 R7 free 6 almost_full", int'(almost_full), 0);
    push(9'h077);
    chk("R9 R7 free 5 almost_full", int'(almost_full), 1);
    drain("R9 data");
  endtask

  // R11: concurrent streaming, writer faster than reader
  task automatic t_stream();
    localparam int N = 300;
    fork
      begin
        int sent = 0;
        bit act = 0;
        logic [DW-1:0] d = '0;
        while (sent < N || act) begin
          @(negedge wr_clk);
          if (act) begin model.push_back(d); sent++; end
          if (sent < N && !full) begin
            d = DW'(sent * 73 + 5); wr_data = d; wr_req_n = 0; act = 1;
          end else begin
            wr_req_n = 1; act = 0;
          end
        end
      end
      begin
        int got = 0;
        bit act = 0;
        logic [DW-1:0] e;
        while (got < N) begin
          @(negedge rd_clk);
          if (act) begin
            e = (model.size() > 0) ? model.pop_front() : '0;
            chk("R11 stream order", int'(rd_data), int'(e));
            got++;
          end
          if (got < N && !empty) begin rd_req_n = 0; rd_arm_n = 0; act = 1; end
          else begin rd_req_n = 1; rd_arm_n = 1; act = 0; end
        end
      end
    join
    settle();
    chk("R11 empty after stream", int'(empty), 1);
  endtask

  initial begin
    t_reset();
    t_oe();
    t_basic();
    t_ae_default();
    t_full();
    t_load();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(WR_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule